// File: doc/BRIEF.md
# Multi-Channel Descriptor Command Engine

This block is the control front end of a memory-to-memory coprocessor. It serves four independent command channels. Software does three things for a channel: it writes a descriptor address into the channel's command pointer, it turns the channel on in a shared enable register, and it adds to the channel's counting semaphore. The engine then reads an eight-word descriptor through a single word-wide memory read port. It presents the command fields to a processing unit, which is modelled here as a start/done handshake, and waits for that unit to finish.

On completion the engine uses the descriptor's control bits to do three things. It may take one count off the semaphore. It may raise the channel's interrupt flag. It may follow the chain pointer to the next descriptor. If the processing unit returns a nonzero status, the engine records that status and halts the channel until software clears it.

When several channels are ready at the same moment, a round-robin arbiter chooses which one runs next. Only one descriptor is in flight at any time. Every register is reached through a plain 32-bit write strobe and a combinational read port.

Top module: `desc_cmd_engine`

## Requirements
- R1: After reset, every register reads zero. This covers the enable register, the flags, and each channel's pointer, semaphore and status. After reset `irq` and `mem_req` are low.
- R2: The register map is as follows:
  - Channel i has its registers at 0x100 + 0x40*i: command pointer at +0x00 (read/write), semaphore at +0x10, status at +0x20 and status clear at +0x28.
  - The global flags are at 0x10, with channel i in bit i. The flag clear register is at 0x18. The enable register is at 0x20; it is 8 bits wide and read/write.
  - A semaphore write adds the low 8 bits of the data to the count. The count saturates at 255.
- R3: A channel starts a descriptor only when all of these hold: its enable bit is 1, its semaphore is nonzero, its pointer has been loaded since it last went idle, and its status is zero. A channel with its enable bit at 0 never starts.
- R4: The engine reads eight words from consecutive word addresses, starting at the command pointer and stepping by 4. In order, the words are: next pointer, control 0, control 1, source, destination, size, payload address, status. `mem_req` and `mem_addr` hold until `mem_ack` is returned.
- R5: After the eighth word, `pu_start` pulses for one cycle. During that pulse the engine presents control 0, control 1, source, destination, size, payload and the channel number. No further memory read begins until `pu_done` arrives.
- R6: If a completion has zero status and control 0 bit 1 is set, the semaphore is decremented by one. If a semaphore write lands in the same cycle, the count becomes the old count plus the written value minus one.
- R7: In these cases a completion sets the channel's flag:
  - control 0 bit 0 is set;
  - the status is nonzero.

  `irq` is the OR of all flags. Writing ones to 0x18 clears the matching flags. A flag that is set in the same cycle as its clear stays set, and flags never drop without a clear.
- R8: When the processing unit reports a nonzero `pu_status`, the engine stores it in the channel status. In that case the semaphore is not decremented and the pointer is not advanced. The channel starts nothing more while its status is nonzero. Writing ones to the status clear register clears only the matching status bits.
- R9: On a completion with zero status, the engine handles the next pointer as follows:
  - If it is nonzero, it becomes the command pointer. The channel continues while its semaphore stays nonzero.
  - If it is zero, the channel goes idle: it leaves its pointer value unchanged but counts as unloaded.
- R10: Round-robin arbitration: among ready channels, the grant goes to the first one found by searching upward from the channel after the last grant. The first grant after reset searches from channel 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address, used for both writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_ack | input | 1 | Read accepted; `mem_rdata` is valid in this cycle |
| mem_rdata | input | 32 | Read word |
| pu_start | output | 1 | One-cycle command pulse to the processing unit |
| pu_chan | output | 2 | Channel that owns the command |
| pu_ctrl0 | output | 32 | Control word 0 |
| pu_ctrl1 | output | 32 | Control word 1 |
| pu_src | output | 32 | Source address |
| pu_dst | output | 32 | Destination address |
| pu_size | output | 32 | Transfer size |
| pu_payload | output | 32 | Payload address |
| pu_done | input | 1 | Processing unit completion |
| pu_status | input | 8 | Completion status; nonzero means error |
| irq | output | 1 | OR of the channel flags |

## Verification
Two pairs of events can land in the same cycle:
- A software semaphore write and a decrementing completion on the same channel.
- A software flag clear and a flag-setting completion on the same channel.

To provoke both collisions, the bench holds back the processing unit's completion. It then asserts `pu_done` in the same cycle as the register write. In the first collision the count read back must equal old count plus addend minus one. In the second the flag must read back still set. A round-robin sweep over all four channels, each running a two-descriptor chain, checks the grant order and every command field against values computed from the descriptor slot numbers.

// File: rtl/cmdeng_pkg.sv
package cmdeng_pkg;
   localparam int DESC_WORDS  = 8;
   localparam int IDX_NEXT    = 0;
   localparam int IDX_CTRL0   = 1;
   localparam int IDX_CTRL1   = 2;
   localparam int IDX_SRC     = 3;
   localparam int IDX_DST     = 4;
   localparam int IDX_SIZE    = 5;
   localparam int IDX_PAYLOAD = 6;
   localparam int C0_IRQ_BIT  = 0;
   localparam int C0_SEMA_BIT = 1;

   typedef enum logic [1:0] {SQ_IDLE, SQ_FETCH, SQ_ISSUE, SQ_WAIT} seq_state_e;

   typedef struct packed {
      logic [31:0] next_ptr;
      logic [31:0] ctrl0;
      logic [31:0] ctrl1;
      logic [31:0] src;
      logic [31:0] dst;
      logic [31:0] size;
      logic [31:0] payload;
   } cmd_t;
endpackage

// File: rtl/cmdeng_rr_arb.sv
module cmdeng_rr_arb #(
   parameter int N  = 4,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   input  logic          take,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] gnt_idx
);
   logic [IW-1:0] last_q;

   always_comb begin
      logic found;
      int   idx;
      found   = 1'b0;
      gnt     = '0;
      gnt_idx = '0;
      for (int k = 1; k <= N; k++) begin
         idx = (int'(last_q) + k) % N;
         if (!found && req[idx]) begin
            found    = 1'b1;
            gnt[idx] = 1'b1;
            gnt_idx  = IW'(idx);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             last_q <= IW'(N - 1);
      else if (take && |gnt)  last_q <= gnt_idx;
   end

   // R10: with competition, the previous winner is never granted again at once
   assert_rr_rotates_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (take && ($countones(req) > 1)) |-> (gnt_idx != last_q));
endmodule

// File: rtl/cmdeng_chan.sv
module cmdeng_chan #(
   parameter int SEMA_W = 8,
   parameter int STAT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              ptr_wr,
   input  logic [31:0]       ptr_wdata,
   input  logic              sema_wr,
   input  logic [SEMA_W-1:0] sema_wdata,
   input  logic              stclr_wr,
   input  logic [STAT_W-1:0] stclr_mask,
   input  logic              done,
   input  logic [STAT_W-1:0] done_status,
   input  logic              done_dec,
   input  logic [31:0]       done_next,
   output logic              ready,
   output logic [31:0]       cmdptr,
   output logic [SEMA_W-1:0] sema,
   output logic [STAT_W-1:0] chstat
);
   localparam logic [SEMA_W:0] SEMA_MAX = {1'b0, {SEMA_W{1'b1}}};

   logic              valid_q;
   logic              done_ok;
   logic [SEMA_W:0]   sum, nxt;
   logic [SEMA_W-1:0] sema_d;

   assign done_ok = done && (done_status == '0);

   always_comb begin
      sum = {1'b0, sema} + (sema_wr ? {1'b0, sema_wdata} : '0);
      nxt = (done_ok && done_dec && (sum != '0)) ? sum - 1'b1 : sum;
      sema_d = (nxt > SEMA_MAX) ? SEMA_MAX[SEMA_W-1:0] : nxt[SEMA_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmdptr  <= '0;
         valid_q <= 1'b0;
         sema    <= '0;
         chstat  <= '0;
      end else begin
         sema <= sema_d;
         if (done_ok) begin
            if (done_next != '0) cmdptr <= done_next;
            else                 valid_q <= 1'b0;
         end else if (ptr_wr) begin
            cmdptr  <= ptr_wdata;
            valid_q <= 1'b1;
         end
         if (done && !done_ok)  chstat <= done_status;
         else if (stclr_wr)     chstat <= chstat & ~stclr_mask;
      end
   end

   assign ready = en && valid_q && (sema != '0) && (chstat == '0);

   // R6: a successful decrementing completion without a write takes exactly one
   assert_sema_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_ok && done_dec && !sema_wr && (sema != '0)) |=> (sema == $past(sema) - 1'b1));
   // R8: recorded error status stays until a clear write
   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((chstat != '0) && !stclr_wr && !done) |=> (chstat == $past(chstat)));
endmodule

// File: rtl/cmdeng_seq.sv
module cmdeng_seq import cmdeng_pkg::*; #(
   parameter int CH_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            launch,
   input  logic [CH_W-1:0] launch_ch,
   input  logic [31:0]     launch_ptr,
   output logic            idle,
   output logic            mem_req,
   output logic [31:0]     mem_addr,
   input  logic            mem_ack,
   input  logic [31:0]     mem_rdata,
   output logic            pu_start,
   output cmd_t            cmd,
   output logic [CH_W-1:0] cur_ch,
   input  logic            pu_done,
   output logic            fin
);
   localparam int WIDX_W = $clog2(DESC_WORDS);
   localparam logic [WIDX_W-1:0] LAST = WIDX_W'(DESC_WORDS - 1);

   seq_state_e        state_q;
   logic [31:0]       addr_q;
   logic [WIDX_W-1:0] widx_q;
   logic [31:0]       words_q [DESC_WORDS-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         addr_q  <= '0;
         widx_q  <= '0;
         cur_ch  <= '0;
         for (int w = 0; w < DESC_WORDS - 1; w++) words_q[w] <= '0;
      end else begin
         case (state_q)
            SQ_IDLE: if (launch) begin
               cur_ch  <= launch_ch;
               addr_q  <= launch_ptr;
               widx_q  <= '0;
               state_q <= SQ_FETCH;
            end
            SQ_FETCH: if (mem_ack) begin
               addr_q <= addr_q + 32'd4;
               if (widx_q == LAST) begin
                  state_q <= SQ_ISSUE;
               end else begin
                  words_q[widx_q] <= mem_rdata;
                  widx_q <= widx_q + 1'b1;
               end
            end
            SQ_ISSUE: state_q <= SQ_WAIT;
            SQ_WAIT:  if (pu_done) state_q <= SQ_IDLE;
            default:  state_q <= SQ_IDLE;
         endcase
      end
   end

   assign idle     = (state_q == SQ_IDLE);
   assign mem_req  = (state_q == SQ_FETCH);
   assign mem_addr = addr_q;
   assign pu_start = (state_q == SQ_ISSUE);
   assign fin      = (state_q == SQ_WAIT) && pu_done;

   assign cmd.next_ptr = words_q[IDX_NEXT];
   assign cmd.ctrl0    = words_q[IDX_CTRL0];
   assign cmd.ctrl1    = words_q[IDX_CTRL1];
   assign cmd.src      = words_q[IDX_SRC];
   assign cmd.dst      = words_q[IDX_DST];
   assign cmd.size     = words_q[IDX_SIZE];
   assign cmd.payload  = words_q[IDX_PAYLOAD];

   // R4: an unanswered request keeps its address
   assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
   // R5: command pulse lasts one cycle and is followed by no read
   assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pu_start |=> (!pu_start && !mem_req));
endmodule

// File: rtl/desc_cmd_engine.sv
module desc_cmd_engine import cmdeng_pkg::*; #(
   parameter int NUM_CH = 4,
   parameter int SEMA_W = 8,
   parameter int STAT_W = 8,
   parameter int REG_AW = 12,
   parameter int EN_W   = 8,
   parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_req,
   output logic [31:0]       mem_addr,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   output logic              pu_start,
   output logic [CH_W-1:0]   pu_chan,
   output logic [31:0]       pu_ctrl0,
   output logic [31:0]       pu_ctrl1,
   output logic [31:0]       pu_src,
   output logic [31:0]       pu_dst,
   output logic [31:0]       pu_size,
   output logic [31:0]       pu_payload,
   input  logic              pu_done,
   input  logic [STAT_W-1:0] pu_status,
   output logic              irq
);
   localparam int A_GFLAG   = 'h10;
   localparam int A_GCLR    = 'h18;
   localparam int A_ENABLE  = 'h20;
   localparam int A_CHBASE  = 'h100;
   localparam int CH_STRIDE = 'h40;
   localparam int O_PTR     = 'h00;
   localparam int O_SEMA    = 'h10;
   localparam int O_STAT    = 'h20;
   localparam int O_STCLR   = 'h28;

   logic [EN_W-1:0]   en_q;
   logic [NUM_CH-1:0] flags_q, flag_set, flag_clr;
   logic [NUM_CH-1:0] ready, gnt;
   logic [CH_W-1:0]   gnt_idx, cur_ch;
   logic              idle, launch, fin;
   cmd_t              cmd;

   logic [31:0]       ch_ptr  [NUM_CH];
   logic [SEMA_W-1:0] ch_sema [NUM_CH];
   logic [STAT_W-1:0] ch_stat [NUM_CH];

   logic              in_ch;
   logic [CH_W-1:0]   sel;
   int unsigned       offs;

   always_comb begin
      int unsigned a;
      a     = 32'(reg_addr);
      in_ch = (a >= A_CHBASE) && (a < A_CHBASE + CH_STRIDE * NUM_CH);
      sel   = CH_W'((a - A_CHBASE) / CH_STRIDE);
      offs  = a % CH_STRIDE;
   end

   wire gwr_en   = reg_wr && (reg_addr == REG_AW'(A_ENABLE));
   wire gwr_clr  = reg_wr && (reg_addr == REG_AW'(A_GCLR));
   wire chwr     = reg_wr && in_ch;

   assign launch = idle && (|gnt);

   cmdeng_rr_arb #(.N(NUM_CH), .IW(CH_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(ready), .take(launch),
      .gnt(gnt), .gnt_idx(gnt_idx));

   cmdeng_seq #(.CH_W(CH_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .launch(launch), .launch_ch(gnt_idx),
      .launch_ptr(ch_ptr[gnt_idx]), .idle(idle),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .pu_start(pu_start), .cmd(cmd), .cur_ch(cur_ch), .pu_done(pu_done), .fin(fin));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      wire hit  = chwr && (sel == CH_W'(i));
      wire mine = fin && (cur_ch == CH_W'(i));
      cmdeng_chan #(.SEMA_W(SEMA_W), .STAT_W(STAT_W)) u_chan (
         .clk(clk), .rst_n(rst_n), .en(en_q[i]),
         .ptr_wr(hit && (offs == O_PTR)), .ptr_wdata(reg_wdata),
         .sema_wr(hit && (offs == O_SEMA)), .sema_wdata(reg_wdata[SEMA_W-1:0]),
         .stclr_wr(hit && (offs == O_STCLR)), .stclr_mask(reg_wdata[STAT_W-1:0]),
         .done(mine), .done_status(pu_status), .done_dec(cmd.ctrl0[C0_SEMA_BIT]),
         .done_next(cmd.next_ptr), .ready(ready[i]),
         .cmdptr(ch_ptr[i]), .sema(ch_sema[i]), .chstat(ch_stat[i]));
      assign flag_set[i] = mine && (cmd.ctrl0[C0_IRQ_BIT] || (pu_status != '0));
      assign flag_clr[i] = gwr_clr && reg_wdata[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= '0;
         flags_q <= '0;
      end else begin
         if (gwr_en) en_q <= reg_wdata[EN_W-1:0];
         flags_q <= (flags_q & ~flag_clr) | flag_set;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (in_ch) begin
         case (offs)
            O_PTR:   reg_rdata = ch_ptr[sel];
            O_SEMA:  reg_rdata = 32'(ch_sema[sel]);
            O_STAT:  reg_rdata = 32'(ch_stat[sel]);
            default: reg_rdata = '0;
         endcase
      end else if (reg_addr == REG_AW'(A_GFLAG)) begin
         reg_rdata = 32'(flags_q);
      end else if (reg_addr == REG_AW'(A_ENABLE)) begin
         reg_rdata = 32'(en_q);
      end
   end

   assign irq        = |flags_q;
   assign pu_chan    = cur_ch;
   assign pu_ctrl0   = cmd.ctrl0;
   assign pu_ctrl1   = cmd.ctrl1;
   assign pu_src     = cmd.src;
   assign pu_dst     = cmd.dst;
   assign pu_size    = cmd.size;
   assign pu_payload = cmd.payload;

   // R7: without a clear write no flag ever drops
   assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !gwr_clr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: tb/desc_cmd_engine_tb.sv
`timescale 1ns/1ps
module desc_cmd_engine_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_ack;
   logic [31:0] mem_addr, mem_rdata;
   logic        pu_start, pu_done, irq;
   logic [1:0]  pu_chan;
   logic [31:0] pu_ctrl0, pu_ctrl1, pu_src, pu_dst, pu_size, pu_payload;
   logic [7:0]  pu_status;

   logic [31:0] mem [512];
   logic        tick = 1'b0;
   logic        auto_pu = 1'b1;
   logic        auto_done = 1'b0, man_done = 1'b0;
   logic [7:0]  hold_status = '0, man_status = '0;
   int          cnt = 0;

   int          log_n = 0;
   logic [1:0]  log_ch  [64];
   logic [31:0] log_src [64], log_dst [64], log_size [64], log_pay [64], log_c0 [64], log_c1 [64];

   int n_chk = 0, n_fail = 0;

   always #10 clk = ~clk;

   desc_cmd_engine u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .pu_start(pu_start), .pu_chan(pu_chan), .pu_ctrl0(pu_ctrl0), .pu_ctrl1(pu_ctrl1),
      .pu_src(pu_src), .pu_dst(pu_dst), .pu_size(pu_size), .pu_payload(pu_payload),
      .pu_done(pu_done), .pu_status(pu_status), .irq(irq));

   assign mem_ack   = mem_req && tick;
   assign mem_rdata = mem[mem_addr[10:2]];
   assign pu_done   = auto_done | man_done;
   assign pu_status = man_done ? man_status : hold_status;

   always @(negedge clk) begin
      tick = ~tick;
      if (pu_start) begin
         log_ch[log_n] = pu_chan;   log_src[log_n] = pu_src;
         log_dst[log_n] = pu_dst;   log_size[log_n] = pu_size;
         log_pay[log_n] = pu_payload;
         log_c0[log_n] = pu_ctrl0;  log_c1[log_n] = pu_ctrl1;
         log_n = log_n + 1;
      end
      if (pu_start && auto_pu) begin
         cnt = 3; auto_done = 1'b0; hold_status = pu_ctrl1[7:0];
      end else if (cnt != 0) begin
         cnt = cnt - 1; auto_done = (cnt == 0);
      end else begin
         auto_done = 1'b0;
      end
   end

   function automatic int cha(int c, int off);
      return 256 + 64 * c + off;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a[11:0]; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk); reg_addr = a[11:0];
      #1 d = reg_rdata;
   endtask

   task automatic rdchk(input string tag, input int a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(tag, v, exp);
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic put_desc(input int slot, input int nslot, input logic [31:0] c0, input logic [31:0] c1);
      int b;
      b = slot * 16;
      mem[b+0] = (nslot == 0) ? 32'h0 : 32'(nslot * 64);
      mem[b+1] = c0;
      mem[b+2] = c1;
      mem[b+3] = 32'h1000 + 32'(slot);
      mem[b+4] = 32'h2000 + 32'(slot);
      mem[b+5] = 32'h30 + 32'(slot);
      mem[b+6] = 32'h4000 + 32'(slot);
      mem[b+7] = 32'hDEAD0000 | 32'(slot);
   endtask

   task automatic chk_entry(input string tag, input int e, input int ch, input int slot);
      chk({tag, " chan"}, 32'(log_ch[e]), 32'(ch));
      chk({tag, " src"},  log_src[e],  32'h1000 + 32'(slot));
      chk({tag, " dst"},  log_dst[e],  32'h2000 + 32'(slot));
      chk({tag, " size"}, log_size[e], 32'h30 + 32'(slot));
      chk({tag, " pay"},  log_pay[e],  32'h4000 + 32'(slot));
   endtask

   initial begin
      #(20 * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < 512; i++) mem[i] = '0;
      waitc(3);
      rst_n = 1'b1;
      waitc(2);

      // R1 reset state
      rdchk("R1 flags", 'h10, 0);
      rdchk("R1 enable", 'h20, 0);
      for (int c = 0; c < 4; c++) begin
         rdchk("R1 ptr", cha(c, 'h00), 0);
         rdchk("R1 sema", cha(c, 'h10), 0);
         rdchk("R1 chstat", cha(c, 'h20), 0);
      end
      chk("R1 irq", 32'(irq), 0);
      chk("R1 mem_req", 32'(mem_req), 0);

      // R10 round-robin sweep, R4/R5 fields, R9 chaining
      for (int c = 0; c < 4; c++) begin
         put_desc(1 + 2*c, 2 + 2*c, 32'h2, 32'h0);
         put_desc(2 + 2*c, 0, 32'h2, 32'h0);
         wr(cha(c, 'h00), 32'((1 + 2*c) * 64));
         wr(cha(c, 'h10), 2);
      end
      rdchk("R2 sema add", cha(2, 'h10), 2);
      wr('h20, 32'hF);
      waitc(400);
      chk("R10 count", 32'(log_n), 8);
      for (int j = 0; j < 8; j++) begin
         chk_entry("R10 R4 R5 rr", j, j % 4, 1 + 2*(j % 4) + j / 4);
         chk("R5 ctrl0", log_c0[j], 32'h2);
      end
      for (int c = 0; c < 4; c++) begin
         rdchk("R6 sema after chain", cha(c, 'h10), 0);
         rdchk("R9 ptr kept at last", cha(c, 'h00), 32'((2 + 2*c) * 64));
      end
      rdchk("R7 no flag without request", 'h10, 0);
      chk("R7 irq low", 32'(irq), 0);

      // R3 disabled channel does not start
      wr('h20, 32'hE);
      put_desc(9, 0, 32'h3, 32'h0);
      wr(cha(0, 'h00), 9 * 64);
      wr(cha(0, 'h10), 1);
      waitc(80);
      chk("R3 disabled no start", 32'(log_n), 8);
      rdchk("R3 sema held", cha(0, 'h10), 1);
      wr('h20, 32'hF);
      waitc(60);
      chk("R3 enabled start", 32'(log_n), 9);
      chk_entry("R4 single", 8, 0, 9);
      chk("R5 ctrl1", log_c1[8], 32'h0);
      rdchk("R6 decrement", cha(0, 'h10), 0);
      rdchk("R7 flag set", 'h10, 32'h1);
      chk("R7 irq high", 32'(irq), 1);
      wr('h18, 32'h1);
      rdchk("R7 flag cleared", 'h10, 0);
      chk("R7 irq cleared", 32'(irq), 0);

      // R9 chain gated by semaphore
      put_desc(10, 11, 32'h2, 32'h0);
      put_desc(11, 12, 32'h2, 32'h0);
      put_desc(12, 0, 32'h2, 32'h0);
      wr(cha(1, 'h00), 10 * 64);
      wr(cha(1, 'h10), 1);
      waitc(80);
      chk("R9 one run", 32'(log_n), 10);
      chk("R9 first src", log_src[9], 32'h100A);
      rdchk("R9 ptr advanced", cha(1, 'h00), 11 * 64);
      rdchk("R9 sema zero", cha(1, 'h10), 0);
      wr(cha(1, 'h10), 5);
      waitc(120);
      chk("R9 resumed", 32'(log_n), 12);
      chk("R9 second src", log_src[10], 32'h100B);
      chk("R9 third src", log_src[11], 32'h100C);
      rdchk("R6 sema 5-2", cha(1, 'h10), 3);
      rdchk("R9 ptr last", cha(1, 'h00), 12 * 64);
      waitc(60);
      chk("R9 zero next idles", 32'(log_n), 12);

      // R6 descriptor without decrement request
      put_desc(13, 0, 32'h0, 32'h0);
      wr(cha(3, 'h00), 13 * 64);
      wr(cha(3, 'h10), 1);
      waitc(60);
      chk("R6 nodec ran", 32'(log_n), 13);
      rdchk("R6 nodec sema", cha(3, 'h10), 1);
      rdchk("R7 no flag", 'h10, 0);

      // R8 error handling
      put_desc(14, 15, 32'h2, 32'h5A);
      put_desc(15, 0, 32'h2, 32'h0);
      wr(cha(3, 'h00), 14 * 64);
      waitc(60);
      chk("R8 err ran", 32'(log_n), 14);
      chk("R8 err src", log_src[13], 32'h100E);
      rdchk("R8 chstat", cha(3, 'h20), 32'h5A);
      rdchk("R7 error flag", 'h10, 32'h8);
      rdchk("R8 no decrement", cha(3, 'h10), 1);
      rdchk("R8 ptr not advanced", cha(3, 'h00), 14 * 64);
      waitc(60);
      chk("R8 halted", 32'(log_n), 14);
      wr(cha(3, 'h28), 32'h0A);
      rdchk("R8 partial clear", cha(3, 'h20), 32'h50);
      wr(cha(3, 'h00), 15 * 64);
      wr(cha(3, 'h28), 32'hFF);
      rdchk("R8 full clear", cha(3, 'h20), 0);
      waitc(60);
      chk("R8 resumed", 32'(log_n), 15);
      chk("R8 resumed src", log_src[14], 32'h100F);
      rdchk("R8 resumed sema", cha(3, 'h10), 0);
      wr('h18, 32'h8);
      rdchk("R7 clear bit3", 'h10, 0);

      // R6 coincident semaphore write and decrement
      auto_pu = 1'b0;
      put_desc(16, 0, 32'h3, 32'h0);
      wr(cha(2, 'h00), 16 * 64);
      wr(cha(2, 'h10), 1);
      while (log_n != 16) @(negedge clk);
      @(negedge clk);
      man_done = 1'b1; man_status = 8'h0;
      reg_wr = 1'b1; reg_addr = 12'(cha(2, 'h10)); reg_wdata = 32'h3;
      @(negedge clk);
      man_done = 1'b0; reg_wr = 1'b0;
      rdchk("R6 coincident add/dec", cha(2, 'h10), 3);
      rdchk("R7 flag ch2", 'h10, 32'h4);

      // R7 coincident set and clear: set wins
      wr(cha(2, 'h00), 16 * 64);
      while (log_n != 17) @(negedge clk);
      @(negedge clk);
      man_done = 1'b1;
      reg_wr = 1'b1; reg_addr = 12'h018; reg_wdata = 32'h4;
      @(negedge clk);
      man_done = 1'b0; reg_wr = 1'b0;
      rdchk("R7 set beats clear", 'h10, 32'h4);
      chk("R7 irq stays", 32'(irq), 1);
      rdchk("R6 sema after second", cha(2, 'h10), 2);
      wr('h18, 32'h4);
      rdchk("R7 final clear", 'h10, 0);
      auto_pu = 1'b1;

      // R2 saturation and enable readback
      wr(cha(0, 'h10), 200);
      wr(cha(0, 'h10), 100);
      rdchk("R2 sema saturates", cha(0, 'h10), 255);
      wr('h20, 32'hA5);
      rdchk("R2 enable readback", 'h20, 32'hA5);
      waitc(40);
      chk("R3 unloaded ptr no start", 32'(log_n), 17);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule